// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave end of a three-wire control link that reaches the configuration and status registers of a transceiver control chip. The master frames each access with an active-high select line, toggles a serial clock, and shares one open-drain data line with the slave. The select line, the serial clock and the data line arrive from pins and are asynchronous to the system clock. The block brings all three into the system clock domain through two-flop synchronisers and finds the serial clock edges there.

A frame carries a 7-bit register address, most significant bit first. A direction bit follows, and then eight data bits, also most significant bit first. For a write, the block issues a one-cycle write strobe toward the register file, together with the address and the data byte. For a read, it takes one snapshot of the register file's read data and shifts that byte out on the shared line. The block only ever pulls the line low or lets it go. If it lets the line go and finds it low, it stops driving until the frame ends.

Top module: `ser3_port`

## Requirements
- R1: While reset is asserted, the data line is released and neither the write strobe nor the read strobe is active.
- R2: A frame is 7 address bits (MSB first), then one direction bit (1 = read, 0 = write), then 8 data bits (MSB first), each sampled at a serial clock rising edge. On a write frame, a single-cycle write strobe carrying the address and the data byte is issued three system clocks after the 16th rising edge.
- R3: On a read frame, a single-cycle read strobe with the address is issued when the direction bit is taken, and the read data is captured in that same cycle. Later changes to the register file do not alter the byte being sent.
- R4: The captured byte is presented on the line MSB first. Each bit appears three system clocks after a rising edge, starting with the direction-bit edge, so the master samples bit 7 down to bit 0 at data edges 1 to 8. The line is released after the eighth data edge.
- R5: The data line is open-drain: the block pulls it low only for a 0 bit of a read byte. It is released at every other time, including between frames.
- R6: If the block is presenting a 1 (released) and finds the line low at a data rising edge, it stops pulling the line for the rest of that frame. The next frame drives normally.
- R7: Select going low at any point ends the frame. A write frame cut short issues no write strobe, and the next frame decodes from its first address bit.
- R8: Rising edges after the 16th bit of a frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Frame select from the pin, active high, asynchronous |
| sclk_i | input | 1 | Serial clock from the pin, asynchronous |
| sdio_i | input | 1 | Level seen on the shared data line |
| sdio_pull_o | output | 1 | 1 pulls the shared data line low; 0 releases it |
| reg_addr_o | output | AW (7) | Register address toward the register file |
| reg_wdata_o | output | DW (8) | Write data toward the register file |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rd_o | output | 1 | One-cycle read strobe at read capture |
| reg_rdata_i | input | DW (8) | Read data from the register file for reg_addr_o |

## Verification
The assertions assume that each serial clock level and each select level lasts well over three system clocks. This lets every pin change pass the synchronisers before the next change arrives, and lets every strobe end before the next edge. The stimulus holds each serial clock phase for eight system clocks. It changes the data line only while the serial clock is low, and it keeps select low for many cycles between frames. A collision is produced by having the master pull the line low during a bit where the slave releases it.

// File: rtl/ser3_pkg.sv
package ser3_pkg;
  typedef enum logic [1:0] {
    PH_HEAD  = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2,
    PH_TAIL  = 2'd3
  } ser3_phase_e;
endpackage

// File: rtl/ser3_sync.sv
module ser3_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o
);
  logic [STAGES:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], d_i};
  end

  // pipe[STAGES-1] is the synchronised level, pipe[STAGES] its previous value
  assign q_o    = pipe[STAGES-1];
  assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/ser3_frame.sv
module ser3_frame
  import ser3_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          rise,
  input  logic          sdi,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          we_o,
  output logic          rd_o,
  output logic          ld_o,
  output logic          sh_o,
  output logic          sh_last_o
);
  localparam int CNT_MAX = (AW > DW) ? AW : DW;
  localparam int CW      = $clog2(CNT_MAX + 1);

  ser3_phase_e   ph, ph_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [AW-1:0] addr_n;
  logic [DW-1:0] wd_n;
  logic          we_n, rd_n;

  always_comb begin
    ph_n      = ph;
    cnt_n     = cnt;
    addr_n    = addr_o;
    wd_n      = wdata_o;
    we_n      = 1'b0;
    rd_n      = 1'b0;
    ld_o      = 1'b0;
    sh_o      = 1'b0;
    sh_last_o = 1'b0;
    if (!cs_s) begin
      ph_n  = PH_HEAD;
      cnt_n = '0;
    end else if (rise) begin
      unique case (ph)
        PH_HEAD: begin
          if (cnt == CW'(AW)) begin
            cnt_n = '0;
            if (sdi) begin
              ph_n = PH_READ;
              rd_n = 1'b1;
              ld_o = 1'b1;
            end else begin
              ph_n = PH_WRITE;
            end
          end else begin
            addr_n = {addr_o[AW-2:0], sdi};
            cnt_n  = cnt + 1'b1;
          end
        end
        PH_WRITE: begin
          wd_n = {wdata_o[DW-2:0], sdi};
          if (cnt == CW'(DW - 1)) begin
            ph_n = PH_TAIL;
            we_n = 1'b1;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        PH_READ: begin
          sh_o = 1'b1;
          if (cnt == CW'(DW - 1)) begin
            ph_n      = PH_TAIL;
            sh_last_o = 1'b1;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_HEAD;
      cnt     <= '0;
      addr_o  <= '0;
      wdata_o <= '0;
      we_o    <= 1'b0;
      rd_o    <= 1'b0;
    end else begin
      ph      <= ph_n;
      cnt     <= cnt_n;
      addr_o  <= addr_n;
      wdata_o <= wd_n;
      we_o    <= we_n;
      rd_o    <= rd_n;
    end
  end
endmodule

// File: rtl/ser3_drv.sv
module ser3_drv #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sdi,
  input  logic          ld,
  input  logic          sh,
  input  logic          sh_last,
  input  logic [DW-1:0] rdata,
  output logic          pull_o,
  output logic          col_o
);
  logic [DW-1:0] shr, sh_n;
  logic          act, act_n, col_n, pull_n;

  always_comb begin
    sh_n  = shr;
    act_n = act;
    col_n = col_o;
    if (!cs_s) begin
      act_n = 1'b0;
      col_n = 1'b0;
    end else if (ld) begin
      sh_n  = rdata;
      act_n = 1'b1;
    end else if (sh) begin
      // released bit yet line low: another driver holds it
      if (act && shr[DW-1] && !sdi) col_n = 1'b1;
      if (sh_last) act_n = 1'b0;
      else         sh_n  = {shr[DW-2:0], 1'b0};
    end
    pull_n = act_n & ~sh_n[DW-1] & ~col_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shr    <= '0;
      act    <= 1'b0;
      col_o  <= 1'b0;
      pull_o <= 1'b0;
    end else begin
      shr    <= sh_n;
      act    <= act_n;
      col_o  <= col_n;
      pull_o <= pull_n;
    end
  end
endmodule

// File: rtl/ser3_port.sv
module ser3_port #(
  parameter int AW          = 7,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_i,
  input  logic          sclk_i,
  input  logic          sdio_i,
  output logic          sdio_pull_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_we_o,
  output logic          reg_rd_o,
  input  logic [DW-1:0] reg_rdata_i
);
  localparam int PINS = 3;

  logic [1:0]      rst_pipe;
  logic            rst_q;
  logic [PINS-1:0] pin_s, pin_rise;
  logic            cs_s, sclk_rise, sdi_s;
  logic            ld, sh, sh_last, collided;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  ser3_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_q),
    .d_i    ({cs_i, sclk_i, sdio_i}),
    .q_o    (pin_s),
    .rise_o (pin_rise)
  );

  assign cs_s      = pin_s[2];
  assign sclk_rise = pin_rise[1];
  assign sdi_s     = pin_s[0];

  ser3_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk       (clk),
    .rst_n     (rst_q),
    .cs_s      (cs_s),
    .rise      (sclk_rise),
    .sdi       (sdi_s),
    .addr_o    (reg_addr_o),
    .wdata_o   (reg_wdata_o),
    .we_o      (reg_we_o),
    .rd_o      (reg_rd_o),
    .ld_o      (ld),
    .sh_o      (sh),
    .sh_last_o (sh_last)
  );

  ser3_drv #(.DW(DW)) u_drv (
    .clk     (clk),
    .rst_n   (rst_q),
    .cs_s    (cs_s),
    .sdi     (sdi_s),
    .ld      (ld),
    .sh      (sh),
    .sh_last (sh_last),
    .rdata   (reg_rdata_i),
    .pull_o  (sdio_pull_o),
    .col_o   (collided)
  );
endmodule

// File: rtl/ser3_chk.sv
module ser3_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic sclk_rise,
  input logic pull,
  input logic we,
  input logic rd,
  input logic collided
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!pull && !we && !rd));

  a_r2_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);

  a_r3_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> !rd);

  a_r3_rd_we_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && we));

  a_r4_pull_moves_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && !sclk_rise) |=> $stable(pull));

  a_r5_no_pull_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !pull);

  a_r6_collision_held: assert property (@(posedge clk) disable iff (!rst_n)
    (collided && cs_s) |=> collided);

  a_r7_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> (!pull && !we && !rd && !collided));
endmodule

bind ser3_port ser3_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_s      (cs_s),
  .sclk_rise (sclk_rise),
  .pull      (sdio_pull_o),
  .we        (reg_we_o),
  .rd        (reg_rd_o),
  .collided  (collided)
);

// File: tb/tb_ser3_port.sv
module tb_ser3_port;
  localparam int HALF = 8;

  logic clk, rst_n, cs, sclk, mdrv;
  logic sdio, pull, we, rd;
  logic [6:0] addr;
  logic [7:0] wdata, rdata;
  logic poke_en;
  logic [6:0] poke_a;
  logic [7:0] poke_v;
  logic [7:0] regfile [128];

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  // model state
  bit [2:0] hist[$];
  int mst, mcnt, maddr, mwd, msh;
  bit mwe, mrd, mact, mcol, mpull;
  int model_mem [128];

  assign sdio = mdrv & ~pull;   // wired-AND with pull-up

  ser3_port dut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sclk_i(sclk), .sdio_i(sdio),
    .sdio_pull_o(pull), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_we_o(we), .reg_rd_o(rd), .reg_rdata_i(rdata)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // register file stub
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 128; k++) regfile[k] <= 8'((k * 7 + 3) & 255);
    end else begin
      if (we) regfile[addr] <= wdata;
      if (poke_en) regfile[poke_a] <= poke_v;
    end
  end
  assign rdata = regfile[addr];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: pins reach the frame logic three clocks late
  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {3'b0, 3'b0, 3'b0, 3'b0};
      mst = 0; mcnt = 0; maddr = 0; mwd = 0; msh = 0;
      mwe = 0; mrd = 0; mact = 0; mcol = 0; mpull = 0;
      for (int k = 0; k < 128; k++) model_mem[k] = (k * 7 + 3) & 255;
    end else begin
      bit [2:0] cur, prv;
      bit rise, d;
      hist.push_back({cs, sclk, mdrv & ~mpull});
      if (hist.size() > 4) void'(hist.pop_front());
      cur = hist[1];
      prv = hist[0];
      rise = cur[1] && !prv[1];
      d = cur[0];
      mwe = 0; mrd = 0;
      if (poke_en) model_mem[poke_a] = poke_v;
      if (!cur[2]) begin
        mst = 0; mcnt = 0; mact = 0; mcol = 0;
      end else if (rise) begin
        case (mst)
          0: if (mcnt == 7) begin
               mcnt = 0;
               if (d) begin mst = 2; mrd = 1; mact = 1; msh = model_mem[maddr]; end
               else mst = 1;
             end else begin
               maddr = ((maddr << 1) | d) & 127; mcnt++;
             end
          1: begin
               mwd = ((mwd << 1) | d) & 255;
               if (mcnt == 7) begin mst = 3; mwe = 1; model_mem[maddr] = mwd; end
               else mcnt++;
             end
          2: begin
               if (mact && msh[7] && !d) mcol = 1;
               if (mcnt == 7) begin mst = 3; mact = 0; end
               else begin msh = (msh << 1) & 255; mcnt++; end
             end
          default: ;
        endcase
      end
      mpull = mact && !msh[7] && !mcol;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(pull == mpull, mcol ? "R6 pull" : "R4 pull", pull, mpull);
      check(we == mwe, "R2 write strobe", we, mwe);
      if (mwe) begin
        check(addr == maddr, "R2 write addr", addr, maddr);
        check(wdata == mwd, "R2 write data", wdata, mwd);
      end
      check(rd == mrd, "R3 read strobe", rd, mrd);
      if (mrd) check(addr == maddr, "R3 read addr", addr, maddr);
    end
  end

  task automatic frame(input int a, input bit is_rd, input int wb, input int nclk,
                       input int jam, input bit do_poke, input int pv, output int rb);
    cs = 1;
    rb = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      if (i < 7) mdrv = a[6 - i];
      else if (i == 7) mdrv = is_rd;
      else if (i < 16 && !is_rd) mdrv = wb[15 - i];
      else mdrv = 1;
      if (is_rd && i >= 8 && i < 16 && (i - 8) == jam) mdrv = 0;
      if (do_poke && i == 10) begin
        poke_en = 1; poke_a = 7'(a); poke_v = 8'(pv);
        @(negedge clk);
        poke_en = 0;
        repeat (HALF - 1) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      sclk = 1;
      if (is_rd && i >= 8 && i < 16) rb = (rb << 1) | int'(sdio);
      repeat (HALF) @(negedge clk);
      sclk = 0;
    end
    mdrv = 1;
    repeat (HALF) @(negedge clk);
    cs = 0;
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int rb;
    rst_n = 0; cs = 0; sclk = 0; mdrv = 1; poke_en = 0; poke_a = 0; poke_v = 0;
    repeat (4) @(negedge clk);
    check(pull == 0, "R1 pull in reset", pull, 0);
    check(we == 0, "R1 we in reset", we, 0);
    check(rd == 0, "R1 rd in reset", rd, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);

    // R2 write then R4 read back
    frame(7'h15, 0, 8'hA5, 16, -1, 0, 0, rb);
    frame(7'h15, 1, 0, 16, -1, 0, 0, rb);
    check(rb == 8'hA5, "R4 read back 0x15", rb, 8'hA5);
    frame(7'h6A, 0, 8'h3C, 16, -1, 0, 0, rb);
    frame(7'h6A, 1, 0, 16, -1, 0, 0, rb);
    check(rb == 8'h3C, "R4 read back 0x6A", rb, 8'h3C);
    frame(7'h01, 1, 0, 16, -1, 0, 0, rb);
    check(rb == 8'h0A, "R4 read reset value", rb, 8'h0A);

    // R7 aborted writes leave the register alone
    frame(7'h15, 0, 8'hFF, 12, -1, 0, 0, rb);
    frame(7'h15, 0, 8'hFF, 15, -1, 0, 0, rb);
    frame(7'h15, 1, 0, 16, -1, 0, 0, rb);
    check(rb == 8'hA5, "R7 aborted write ignored", rb, 8'hA5);
    frame(7'h6A, 1, 0, 9, -1, 0, 0, rb);
    frame(7'h6A, 1, 0, 16, -1, 0, 0, rb);
    check(rb == 8'h3C, "R7 decode after aborted read", rb, 8'h3C);

    // R3 capture is taken once
    frame(7'h6A, 1, 0, 16, -1, 1, 8'h00, rb);
    check(rb == 8'h3C, "R3 captured byte kept", rb, 8'h3C);
    frame(7'h6A, 1, 0, 16, -1, 0, 0, rb);
    check(rb == 8'h00, "R3 new value next frame", rb, 8'h00);

    // R6 collision: master holds bit 6 low, slave gives up
    frame(7'h22, 0, 8'hF0, 16, -1, 0, 0, rb);
    frame(7'h22, 1, 0, 16, 1, 0, 0, rb);
    check(rb == 8'hBF, "R6 slave silent after collision", rb, 8'hBF);
    frame(7'h22, 1, 0, 16, -1, 0, 0, rb);
    check(rb == 8'hF0, "R6 drives again next frame", rb, 8'hF0);

    // R8 extra clocks ignored
    frame(7'h40, 0, 8'h81, 20, -1, 0, 0, rb);
    frame(7'h40, 1, 0, 22, -1, 0, 0, rb);
    check(rb == 8'h81, "R8 over-length frames", rb, 8'h81);

    // R5 line released between frames
    check(sdio == 1, "R5 line released when idle", sdio, 1);
    check(pull == 0, "R5 no pull when idle", pull, 0);

    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule